// File: doc/BRIEF.md
# Quasi-Resonant Valley Switching Timer

This block times the power switch of a flyback converter that runs in quasi-resonant mode. Each off period opens with a blanking window. After that window a minimum off-time applies, and its length depends on load: it stays short at heavy load and grows linearly as the digitised feedback level drops toward light load. Valley-detect flags are honoured only after this minimum off-time. An accepted valley turns the switch on after a short fixed delay. If no valley arrives within a time-out window, the switch turns on anyway. The on period ends on the peak-current flag or at a hard on-time cap, whichever comes first.

While the switch is off and blanking has ended, the block also samples the plateau over-voltage comparator on every clock. A long unbroken run of asserted samples, summed across off periods, raises a single-cycle fault pulse. All inputs are synchronous level flags that the block samples on every clock, so the block has no valid/ready handshake and nothing to back-pressure. The feedback code is read once per off period, on the clock edge where the switch turns off.

All times are parameters counted in clock cycles. The defaults assume a 200 MHz clock: 4 µs blanking, 8.5 µs and 36 µs minimum off-time, 200 ns valley delay, 6 µs time-out, 46 µs on-time cap and 170 µs of over-voltage samples.

Top module: `qr_valley_timer`

## Requirements
- R1: While reset is asserted, `gate_o` and `ovp_fault_o` are low. Reset leaves the block in an off period that uses the high-load minimum off-time. With no valley, the first turn-on is the `MIN_OFF_HI + TIMEOUT`-th rising clock edge after reset is released.
- R2: The minimum off-time `M` is latched from `fb_code_i` on the edge where the gate turns off. The feedback code is 1 LSB = 20 mV, so 105 = 2.1 V and 60 = 1.2 V. `M = MIN_OFF_HI` for codes at or above `FB_HI_CODE`. `M = MIN_OFF_LO` for codes at or below `FB_LO_CODE`. Between them, `M = MIN_OFF_HI + floor((MIN_OFF_LO-MIN_OFF_HI)*(FB_HI_CODE-code)/(FB_HI_CODE-FB_LO_CODE))`.
- R3: Off-period cycle k counts from 1 at the first edge after turn-off. A valley flag seen at cycle k is ignored when k < M or k < `BLANK`.
- R4: A valley seen at an accepted cycle k with M <= k < M+`TIMEOUT` makes the gate rise exactly `VALLEY_DLY` cycles later, so the off time is k+`VALLEY_DLY`.
- R5: If no valley is accepted before cycle M+`TIMEOUT`, the gate rises at that cycle, so the off time is M+`TIMEOUT`.
- R6: Once a valley has been accepted, later valley flags in the same off period have no effect on when the gate rises.
- R7: The gate stays high for at most `MAX_ON` cycles.
- R8: A peak-current flag seen at on-period cycle k ends the on period there, so the gate is high for k cycles.
- R9: A plateau sample is taken at each off cycle k >= `BLANK`. After `OVP_SAMPLES` consecutive asserted samples, counted across off periods, `ovp_fault_o` pulses high for one cycle and the count restarts. A deasserted sample clears the count.
- R10: The plateau flag has no effect during the on period or during the blanking cycles of the off period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| valley_i | input | 1 | Valley comparator flag, synchronous |
| peak_i | input | 1 | Peak-current comparator flag, synchronous |
| fb_code_i | input | FB_W | Digitised feedback level |
| plat_ovp_i | input | 1 | Plateau over-voltage comparator flag |
| gate_o | output | 1 | Switch drive, high = on |
| ovp_fault_o | output | 1 | Single-cycle plateau over-voltage fault pulse |

## Verification
A wrong cycle counter or a stuck scheduling flag shows at the ports within one switching period. It appears as an off time or on time that is a few cycles away from the value the requirements give, so the bench measures each period to the exact cycle. A wrong minimum off-time latch appears in the first off period after the feedback code changes. A fault in the over-voltage accumulator appears only after several off periods, as a missing pulse, an early pulse or a pulse wider than one cycle. The checks therefore place their sample boundaries a few periods either side of the threshold.

// File: rtl/qr_timer_pkg.sv
package qr_timer_pkg;
  typedef enum logic {
    PH_OFF = 1'b0,
    PH_ON  = 1'b1
  } phase_t;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/qr_min_off_calc.sv
module qr_min_off_calc #(
  parameter int FB_W       = 8,
  parameter int FB_HI_CODE = 105,
  parameter int FB_LO_CODE = 60,
  parameter int MIN_OFF_HI = 1700,
  parameter int MIN_OFF_LO = 7200,
  parameter int CNT_W      = 16
) (
  input  logic [FB_W-1:0]  fb_code_i,
  output logic [CNT_W-1:0] min_off_o
);
  localparam int SPAN_T = MIN_OFF_LO - MIN_OFF_HI;
  localparam int SPAN_F = FB_HI_CODE - FB_LO_CODE;

  logic [31:0] fb_ext;
  assign fb_ext = 32'(fb_code_i);

  generate
    if (SPAN_F <= 0) begin : g_step
      // Degenerate curve: single threshold, no ramp
      always_comb begin
        if (fb_ext >= 32'(FB_HI_CODE)) min_off_o = CNT_W'(MIN_OFF_HI);
        else                           min_off_o = CNT_W'(MIN_OFF_LO);
      end
    end else begin : g_ramp
      logic [31:0] delta;
      logic [31:0] prod;
      logic [31:0] quot;
      always_comb begin
        delta = 32'(FB_HI_CODE) - fb_ext;
        prod  = delta * 32'(SPAN_T);
        quot  = prod / 32'(SPAN_F);
        if (fb_ext >= 32'(FB_HI_CODE))      min_off_o = CNT_W'(MIN_OFF_HI);
        else if (fb_ext <= 32'(FB_LO_CODE)) min_off_o = CNT_W'(MIN_OFF_LO);
        else                                min_off_o = CNT_W'(32'(MIN_OFF_HI) + quot);
      end
    end
  endgenerate
endmodule

// File: rtl/qr_gate_seq.sv
module qr_gate_seq
  import qr_timer_pkg::*;
#(
  parameter int MIN_OFF_HI = 1700,
  parameter int BLANK      = 800,
  parameter int VALLEY_DLY = 40,
  parameter int TIMEOUT    = 1200,
  parameter int MAX_ON     = 9200,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valley_i,
  input  logic             peak_i,
  input  logic [CNT_W-1:0] min_off_next_i,
  output logic             gate_o,
  output logic             samp_en_o
);
  localparam int DLY_W = (VALLEY_DLY > 1) ? $clog2(VALLEY_DLY) : 1;
  localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(VALLEY_DLY - 1);

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] min_off_q;
  logic [DLY_W-1:0] dly;
  logic             sched;

  logic [CNT_W-1:0] win_end;
  logic             past_blank;
  logic             valley_open;
  logic             timed_out;
  logic             on_end;

  assign win_end     = min_off_q + CNT_W'(TIMEOUT);
  assign past_blank  = (cnt >= CNT_W'(BLANK));
  assign valley_open = past_blank && (cnt >= min_off_q) && (cnt < win_end);
  assign timed_out   = (cnt >= win_end);
  assign on_end      = peak_i || (cnt >= CNT_W'(MAX_ON));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_OFF;
      cnt       <= CNT_W'(1);
      min_off_q <= CNT_W'(MIN_OFF_HI);
      dly       <= '0;
      sched     <= 1'b0;
    end else begin
      cnt <= cnt + CNT_W'(1);
      unique case (phase)
        PH_ON: begin
          if (on_end) begin
            phase     <= PH_OFF;
            cnt       <= CNT_W'(1);
            min_off_q <= min_off_next_i;
            sched     <= 1'b0;
            dly       <= '0;
          end
        end
        PH_OFF: begin
          if (sched) begin
            if (dly == DLY_LAST) begin
              phase <= PH_ON;
              cnt   <= CNT_W'(1);
              sched <= 1'b0;
            end else begin
              dly <= dly + DLY_W'(1);
            end
          end else if (timed_out) begin
            phase <= PH_ON;
            cnt   <= CNT_W'(1);
          end else if (valley_i && valley_open) begin
            sched <= 1'b1;
            dly   <= '0;
          end
        end
        default: phase <= PH_OFF;
      endcase
    end
  end

  assign gate_o    = (phase == PH_ON);
  assign samp_en_o = (phase == PH_OFF) && past_blank;
endmodule

// File: rtl/qr_plateau_ovp.sv
module qr_plateau_ovp #(
  parameter int OVP_SAMPLES = 34000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic samp_en_i,
  input  logic plat_i,
  output logic fault_o
);
  localparam int OW = $clog2(OVP_SAMPLES + 1);
  localparam logic [OW-1:0] LAST = OW'(OVP_SAMPLES - 1);

  logic [OW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      fault_o <= 1'b0;
    end else begin
      fault_o <= 1'b0;
      if (samp_en_i) begin
        if (!plat_i) begin
          run_cnt <= '0;
        end else if (run_cnt == LAST) begin
          run_cnt <= '0;
          fault_o <= 1'b1;
        end else begin
          run_cnt <= run_cnt + OW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/qr_valley_timer.sv
module qr_valley_timer
  import qr_timer_pkg::*;
#(
  parameter int FB_W        = 8,
  parameter int FB_HI_CODE  = 105,
  parameter int FB_LO_CODE  = 60,
  parameter int MIN_OFF_HI  = 1700,
  parameter int MIN_OFF_LO  = 7200,
  parameter int BLANK       = 800,
  parameter int VALLEY_DLY  = 40,
  parameter int TIMEOUT     = 1200,
  parameter int MAX_ON      = 9200,
  parameter int OVP_SAMPLES = 34000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valley_i,
  input  logic            peak_i,
  input  logic [FB_W-1:0] fb_code_i,
  input  logic            plat_ovp_i,
  output logic            gate_o,
  output logic            ovp_fault_o
);
  localparam int LONGEST = max_of(MIN_OFF_LO + TIMEOUT + VALLEY_DLY, MAX_ON);
  localparam int CNT_W   = $clog2(LONGEST + 2) + 1;

  logic [CNT_W-1:0] min_off_next;
  logic             samp_en;

  qr_min_off_calc #(
    .FB_W(FB_W), .FB_HI_CODE(FB_HI_CODE), .FB_LO_CODE(FB_LO_CODE),
    .MIN_OFF_HI(MIN_OFF_HI), .MIN_OFF_LO(MIN_OFF_LO), .CNT_W(CNT_W)
  ) u_calc (
    .fb_code_i(fb_code_i),
    .min_off_o(min_off_next)
  );

  qr_gate_seq #(
    .MIN_OFF_HI(MIN_OFF_HI), .BLANK(BLANK), .VALLEY_DLY(VALLEY_DLY),
    .TIMEOUT(TIMEOUT), .MAX_ON(MAX_ON), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk),
    .rst_n(rst_n),
    .valley_i(valley_i),
    .peak_i(peak_i),
    .min_off_next_i(min_off_next),
    .gate_o(gate_o),
    .samp_en_o(samp_en)
  );

  qr_plateau_ovp #(.OVP_SAMPLES(OVP_SAMPLES)) u_ovp (
    .clk(clk),
    .rst_n(rst_n),
    .samp_en_i(samp_en),
    .plat_i(plat_ovp_i),
    .fault_o(ovp_fault_o)
  );
endmodule

// File: rtl/qr_valley_timer_chk.sv
module qr_valley_timer_chk #(
  parameter int MIN_OFF_HI = 1700,
  parameter int MIN_OFF_LO = 7200,
  parameter int VALLEY_DLY = 40,
  parameter int TIMEOUT    = 1200,
  parameter int MAX_ON     = 9200
) (
  input logic clk,
  input logic rst_n,
  input logic gate_o,
  input logic peak_i,
  input logic ovp_fault_o
);
  localparam int MAX_OFF = MIN_OFF_LO + TIMEOUT + VALLEY_DLY;

  int hi_run;
  int lo_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= 0;
      lo_run <= 0;
    end else begin
      hi_run <= gate_o ? hi_run + 1 : 0;
      lo_run <= gate_o ? 0 : lo_run + 1;
    end
  end

  // R7
  on_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_o |-> (hi_run < MAX_ON));

  // R5
  off_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_o |-> (lo_run < MAX_OFF));

  // R3
  off_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_o) |-> (lo_run >= MIN_OFF_HI));

  // R8
  peak_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_o && peak_i) |=> !gate_o);

  // R9
  fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovp_fault_o |=> !ovp_fault_o);
endmodule

bind qr_valley_timer qr_valley_timer_chk #(
  .MIN_OFF_HI(MIN_OFF_HI), .MIN_OFF_LO(MIN_OFF_LO), .VALLEY_DLY(VALLEY_DLY),
  .TIMEOUT(TIMEOUT), .MAX_ON(MAX_ON)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .gate_o(gate_o),
  .peak_i(peak_i),
  .ovp_fault_o(ovp_fault_o)
);

// File: tb/qr_valley_timer_tb.sv
`timescale 1ns/1ps
module qr_valley_timer_tb;
  localparam int FB_HI  = 105;
  localparam int FB_LO  = 60;
  localparam int T_HI   = 40;
  localparam int T_LO   = 130;
  localparam int BLANK  = 20;
  localparam int DLY    = 5;
  localparam int TO     = 30;
  localparam int MAXON  = 100;
  localparam int OVPN   = 300;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valley = 1'b0;
  logic       peak = 1'b0;
  logic [7:0] fb = 8'd200;
  logic       plat = 1'b0;
  logic       gate;
  logic       fault;

  int n_checks = 0;
  int n_fail   = 0;
  int fault_seen = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  qr_valley_timer #(
    .FB_W(8), .FB_HI_CODE(FB_HI), .FB_LO_CODE(FB_LO),
    .MIN_OFF_HI(T_HI), .MIN_OFF_LO(T_LO), .BLANK(BLANK),
    .VALLEY_DLY(DLY), .TIMEOUT(TO), .MAX_ON(MAXON), .OVP_SAMPLES(OVPN)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .valley_i(valley), .peak_i(peak),
    .fb_code_i(fb), .plat_ovp_i(plat), .gate_o(gate), .ovp_fault_o(fault)
  );

  always @(negedge clk) if (rst_n && fault === 1'b1) fault_seen++;

  function automatic int exp_min_off(input int code);
    if (code >= FB_HI) return T_HI;
    if (code <= FB_LO) return T_LO;
    return T_HI + ((T_LO - T_HI) * (FB_HI - code)) / (FB_HI - FB_LO);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; valley = 0; peak = 0; plat = 0; fb = 8'd200;
    repeat (3) @(negedge clk);
    fault_seen = 0;
    rst_n = 1'b1;
  endtask

  // Called at the negedge right after the gate fell (or reset release).
  task automatic off_loop(input int v1, input int v2, input int hold, input int pm,
                          output int len);
    int i;
    i = 1; len = 0;
    forever begin
      valley = (i == v1) || (i == v2) || (hold > 0 && i >= hold);
      plat   = (pm == 1) || (pm == 2 && i < BLANK);
      if (gate !== 1'b0) break;
      len = i;
      @(negedge clk);
      i++;
    end
    valley = 1'b0;
  endtask

  // Called at the negedge right after the gate rose.
  task automatic on_loop(input int trip, input int pm, output int len);
    int i;
    i = 1; len = 0;
    forever begin
      peak = (i == trip);
      plat = (pm != 0);
      if (gate !== 1'b1) break;
      len = i;
      @(negedge clk);
      i++;
    end
    peak = 1'b0;
  endtask

  task automatic run_cycle(input int trip, input int v1, input int v2, input int hold,
                           input int pm, output int on_len, output int off_len);
    on_loop(trip, pm, on_len);
    off_loop(v1, v2, hold, pm, off_len);
  endtask

  task automatic t_reset();
    int len;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(gate === 1'b0, "R1 gate in reset", int'(gate), 0);
    check(fault === 1'b0, "R1 fault in reset", int'(fault), 0);
    do_reset();
    off_loop(0, 0, 0, 0, len);
    check(len == T_HI + TO, "R1 first off after reset", len, T_HI + TO);
  endtask

  task automatic t_min_off();
    int codes[6] = '{200, 105, 60, 10, 80, 81};
    int on_len, off_len, exp;
    do_reset();
    off_loop(0, 0, 0, 0, off_len);
    foreach (codes[j]) begin
      fb = 8'(codes[j]);
      run_cycle(0, 0, 0, 0, 0, on_len, off_len);
      exp = exp_min_off(codes[j]) + TO;
      check(off_len == exp, $sformatf("R2/R5 min off fb=%0d", codes[j]), off_len, exp);
    end
    fb = 8'd200;
  endtask

  task automatic t_valley();
    int on_len, off_len;
    do_reset();
    off_loop(0, 0, 0, 0, off_len);
    run_cycle(0, 10, 0, 0, 0, on_len, off_len);
    check(off_len == T_HI + TO, "R3 valley in blanking ignored", off_len, T_HI + TO);
    run_cycle(0, T_HI - 1, 0, 0, 0, on_len, off_len);
    check(off_len == T_HI + TO, "R3 valley one before min off ignored", off_len, T_HI + TO);
    run_cycle(0, 45, 0, 0, 0, on_len, off_len);
    check(off_len == 45 + DLY, "R4 valley accepted", off_len, 45 + DLY);
    run_cycle(0, 0, 0, 1, 0, on_len, off_len);
    check(off_len == T_HI + DLY, "R4 held valley at min off", off_len, T_HI + DLY);
    run_cycle(0, 42, 44, 0, 0, on_len, off_len);
    check(off_len == 42 + DLY, "R6 second valley ignored", off_len, 42 + DLY);
    run_cycle(0, T_HI + TO - 1, 0, 0, 0, on_len, off_len);
    check(off_len == T_HI + TO - 1 + DLY, "R4 last window cycle", off_len, T_HI + TO - 1 + DLY);
    run_cycle(0, T_HI + TO, 0, 0, 0, on_len, off_len);
    check(off_len == T_HI + TO, "R5 valley at timeout", off_len, T_HI + TO);
  endtask

  task automatic t_peak();
    int on_len, off_len;
    do_reset();
    off_loop(0, 0, 0, 0, off_len);
    run_cycle(7, 0, 0, 0, 0, on_len, off_len);
    check(on_len == 7, "R8 peak ends on", on_len, 7);
    run_cycle(1, 0, 0, 0, 0, on_len, off_len);
    check(on_len == 1, "R8 peak first cycle", on_len, 1);
    run_cycle(0, 0, 0, 0, 0, on_len, off_len);
    check(on_len == MAXON, "R7 on cap", on_len, MAXON);
  endtask

  task automatic t_ovp();
    int on_len, off_len;
    // 51 samples per timeout off period (cycles 20..70)
    do_reset();
    off_loop(0, 0, 0, 1, off_len);
    repeat (4) run_cycle(0, 0, 0, 0, 1, on_len, off_len);
    check(fault_seen == 0, "R9 no fault below count", fault_seen, 0);
    run_cycle(0, 0, 0, 0, 1, on_len, off_len);
    check(fault_seen == 1, "R9 fault at count", fault_seen, 1);

    do_reset();
    off_loop(0, 0, 0, 1, off_len);
    repeat (3) run_cycle(0, 0, 0, 0, 1, on_len, off_len);
    run_cycle(0, 0, 0, 0, 0, on_len, off_len);
    repeat (5) run_cycle(0, 0, 0, 0, 1, on_len, off_len);
    check(fault_seen == 0, "R9 low sample clears count", fault_seen, 0);
    run_cycle(0, 0, 0, 0, 1, on_len, off_len);
    check(fault_seen == 1, "R9 fault after restart", fault_seen, 1);

    do_reset();
    off_loop(0, 0, 0, 2, off_len);
    repeat (8) run_cycle(0, 0, 0, 0, 2, on_len, off_len);
    check(fault_seen == 0, "R10 plateau ignored in on and blanking", fault_seen, 0);
    plat = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_min_off();
    t_valley();
    t_peak();
    t_ovp();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule